// File: doc/BRIEF.md
# Charge Pump Ratio Sequencer

This block chooses the multiplication ratio of a four-ratio LED charge pump (1x, 1.33x, 1.5x, 2x). Every cycle it looks at a set of per-channel headroom comparator flags and a "unity ratio would suffice" flag. These are synchronous digital stand-ins for the analog sensing. From them it decides whether to climb one ratio or to fall back to 1x. Only channels that are driven and not faulted take part in the decision, so the channel with the least headroom decides alone.

Every ratio change starts a settle window of `SETTLE_CYC` clock cycles, counted from the system clock. No further change is taken until the window has expired. When even 2x lacks headroom, the sequencer wraps to 1x and climbs again. While the LEDs are dark during a PWM off phase, no channel raises a request, so the pump holds its ratio. Dropping `enable` parks the machine in an idle state with no ratio selected. Raising `enable` again always restarts at 1x.

Top module: `pump_ratio_seq`

## Requirements
- R1: While `enable` is low (and after reset), the next clock edge leaves `ratio_sel` = 4'b0000 and `reg_good` = 0.
- R2: On the first clock edge with `enable` high after idle, `ratio_sel` becomes 4'b0001 (1x), and a settle window begins.
- R3: `ratio_sel` is one-hot with bit0 = 1x, bit1 = 1.33x, bit2 = 1.5x, bit3 = 2x. A step-up moves the set bit exactly one position upward.
- R4: A step-up request is the OR, over channels, of `ch_low[i]` with `ch_on[i]` = 1 and `ch_fault[i]` = 0. Flags of channels that are off or faulted have no effect.
- R5: After any ratio change, `ratio_sel` holds for `SETTLE_CYC` clock edges, and requests in that window are ignored. With a request present continuously, successive changes are exactly `SETTLE_CYC` edges apart.
- R6: With the window expired, no request and `unity_ok` = 1, the ratio returns to 1x. It never steps down to 1.33x or 1.5x. A request takes priority over `unity_ok`.
- R7: A request in 2x with the window expired wraps the ratio to 1x, and the climb repeats while the request stays.
- R8: With no active request and `unity_ok` = 0 (for example all `ch_on` low during PWM off time), the ratio is held indefinitely.
- R9: `reg_good` is 1 exactly when a ratio is selected, the settle window has expired and no active request is present.
- R10: While enabled, exactly one bit of `ratio_sel` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the timebase of the settle window |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Sequencer run request; low forces idle |
| ch_on | input | NCH | Channel is enabled and in its PWM on phase |
| ch_fault | input | NCH | Channel is faulted (shorted or unused) and excluded |
| ch_low | input | NCH | Regulator headroom below threshold on the channel |
| unity_ok | input | 1 | 1x ratio would now regulate all channels |
| ratio_sel | output | 4 | One-hot ratio select, bit0 1x up to bit3 2x |
| reg_good | output | 1 | Regulation settled and no headroom shortfall |

## Verification
Assertions check the following on every cycle: the ratio select is one-hot while running and clear while idle, entry from idle lands on 1x, the ratio holds while the settle window runs, each taken request rotates the select by one position (wrapping 2x to 1x), a taken fall-back lands on 1x, and `reg_good` appears only with a settled, selected ratio. The exact spacing of changes in settle-window cycles is shown only by the bench scenarios. So are the masking of off and faulted channels, the ratio hold through long PWM off phases, and the priority of requests over `unity_ok`. The bench runs each of these against a cycle-by-cycle reference model.

// File: rtl/crp_pkg.sv
package crp_pkg;

  localparam int unsigned NUM_RATIOS = 4;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_X100  = 3'd1,
    ST_X133  = 3'd2,
    ST_X150  = 3'd3,
    ST_X200  = 3'd4
  } ratio_st_e;

  // Next ratio on a climb; the top ratio wraps to unity.
  function automatic ratio_st_e climb(input ratio_st_e cur);
    case (cur)
      ST_X100: climb = ST_X133;
      ST_X133: climb = ST_X150;
      ST_X150: climb = ST_X200;
      default: climb = ST_X100;
    endcase
  endfunction

  function automatic logic [NUM_RATIOS-1:0] to_onehot(input ratio_st_e st);
    case (st)
      ST_X100: to_onehot = 4'b0001;
      ST_X133: to_onehot = 4'b0010;
      ST_X150: to_onehot = 4'b0100;
      ST_X200: to_onehot = 4'b1000;
      default: to_onehot = 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/crp_rst_sync.sv
module crp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = shreg[STAGES-1];
endmodule

// File: rtl/crp_demand.sv
module crp_demand #(
  parameter int unsigned NCH = 6
) (
  input  logic [NCH-1:0] ch_on,
  input  logic [NCH-1:0] ch_fault,
  input  logic [NCH-1:0] ch_low,
  output logic           demand
);
  logic [NCH-1:0] qual_low;

  // Each channel only votes while it is driven and healthy.
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign qual_low[i] = ch_low[i] & ch_on[i] & ~ch_fault[i];
  end

  assign demand = |qual_low;
endmodule

// File: rtl/crp_settle.sv
module crp_settle #(
  parameter int unsigned SETTLE_CYC = 800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic load,
  output logic busy
);
  localparam int unsigned CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | load | (cnt_q != '0);
    cnt_d  = cnt_q;
    if (clr)                cnt_d = '0;
    else if (load)          cnt_d = RELOAD;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> (cnt_q == RELOAD));
endmodule

// File: rtl/crp_ratio_fsm.sv
module crp_ratio_fsm
  import crp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic                  demand,
  input  logic                  unity_ok,
  input  logic                  busy,
  output logic                  change,
  output logic                  active,
  output logic [NUM_RATIOS-1:0] ratio_sel
);
  ratio_st_e st_q, st_d;

  always_comb begin
    st_d   = st_q;
    change = 1'b0;
    if (!enable) begin
      st_d = ST_IDLE;
    end else if (st_q == ST_IDLE) begin
      st_d   = ST_X100;
      change = 1'b1;
    end else if (!busy) begin
      if (demand) begin
        st_d   = climb(st_q);
        change = 1'b1;
      end else if (unity_ok && st_q != ST_X100) begin
        st_d   = ST_X100;
        change = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign active    = (st_q != ST_IDLE);
  assign ratio_sel = to_onehot(st_q);

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (ratio_sel == 4'b0000));

  p_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && enable) |=> (ratio_sel == 4'b0001));

  p_rotate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && enable && !busy && demand) |=>
      (ratio_sel == {$past(ratio_sel[2:0]), $past(ratio_sel[3])}));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && enable && busy) |=> $stable(ratio_sel));

  p_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && enable && !busy && !demand && unity_ok) |=> (ratio_sel == 4'b0001));

  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ($countones(ratio_sel) == 1));
endmodule

// File: rtl/pump_ratio_seq.sv
module pump_ratio_seq
  import crp_pkg::*;
#(
  parameter int unsigned NCH        = 6,
  parameter int unsigned SETTLE_CYC = 800
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic [NCH-1:0]        ch_on,
  input  logic [NCH-1:0]        ch_fault,
  input  logic [NCH-1:0]        ch_low,
  input  logic                  unity_ok,
  output logic [NUM_RATIOS-1:0] ratio_sel,
  output logic                  reg_good
);
  logic rst_sync_n;
  logic demand, busy, change, active;

  crp_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  crp_demand #(.NCH(NCH)) u_dem (
    .ch_on    (ch_on),
    .ch_fault (ch_fault),
    .ch_low   (ch_low),
    .demand   (demand)
  );

  crp_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (!enable),
    .load  (change),
    .busy  (busy)
  );

  crp_ratio_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .enable    (enable),
    .demand    (demand),
    .unity_ok  (unity_ok),
    .busy      (busy),
    .change    (change),
    .active    (active),
    .ratio_sel (ratio_sel)
  );

  assign reg_good = active & ~busy & ~demand;

  p_good_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_good |-> (($countones(ratio_sel) == 1) && !busy));
endmodule

// File: tb/tb_pump_ratio_seq.sv
module tb_pump_ratio_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 6;
  localparam int S   = 12;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           enable;
  logic [NCH-1:0] ch_on, ch_fault, ch_low;
  logic           unity_ok;
  logic [3:0]     ratio_sel;
  logic           reg_good;

  int    checks = 0;
  int    errors = 0;
  string req = "R1";

  // Reference state: 0 idle, 1..4 = 1x,1.33x,1.5x,2x
  int m_mode = 0;
  int m_wait = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pump_ratio_seq #(.NCH(NCH), .SETTLE_CYC(S)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ch_on(ch_on),
    .ch_fault(ch_fault), .ch_low(ch_low), .unity_ok(unity_ok),
    .ratio_sel(ratio_sel), .reg_good(reg_good)
  );

  function automatic bit want_up();
    for (int i = 0; i < NCH; i++)
      if (ch_low[i] && ch_on[i] && !ch_fault[i]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [3:0] exp_sel();
    return (m_mode == 0) ? 4'b0000 : 4'(1 << (m_mode - 1));
  endfunction

  always @(posedge clk) begin
    if (!rst_n || !enable) begin
      m_mode = 0; m_wait = 0;
    end else if (m_mode == 0) begin
      m_mode = 1; m_wait = S - 1;
    end else if (m_wait != 0) begin
      m_wait = m_wait - 1;
    end else if (want_up()) begin
      m_mode = (m_mode == 4) ? 1 : m_mode + 1; m_wait = S - 1;
    end else if (unity_ok && m_mode != 1) begin
      m_mode = 1; m_wait = S - 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (ratio_sel !== exp_sel()) begin
        errors++;
        $display("FAIL %s ratio_sel actual=%b expected=%b t=%0t", req, ratio_sel, exp_sel(), $time);
      end
      checks++;
      if (reg_good !== (m_mode != 0 && m_wait == 0 && !want_up())) begin
        errors++;
        $display("FAIL %s reg_good actual=%b expected=%b t=%0t", req, reg_good,
                 (m_mode != 0 && m_wait == 0 && !want_up()), $time);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s directed actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; ch_on = '1; ch_fault = '0; ch_low = '0; unity_ok = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(5);
    req = "R1"; chk("R1 reset idle", ratio_sel, 4'b0000);

    // R2/R9: start in 1x, good after the window
    req = "R2"; enable = 1'b1; step(1);
    chk("R2 entry 1x", ratio_sel, 4'b0001);
    req = "R9"; step(S + 2);
    chk("R9 good settled", {3'b0, reg_good}, 4'b0001);

    // R3/R5: climb with persistent demand on channel 2
    enable = 1'b0; step(2);
    req = "R3"; ch_low = 6'b000100; enable = 1'b1; step(1);
    chk("R3 start", ratio_sel, 4'b0001);
    step(S - 1); chk("R5 held to window end", ratio_sel, 4'b0001);
    step(1);     chk("R3 to 1.33x", ratio_sel, 4'b0010);
    step(S);     chk("R3 to 1.5x", ratio_sel, 4'b0100);
    step(S);     chk("R3 to 2x", ratio_sel, 4'b1000);
    req = "R7"; step(S); chk("R7 wrap to 1x", ratio_sel, 4'b0001);
    step(3 * S); chk("R7 climb again", ratio_sel, 4'b1000);

    // R4: masked channels do nothing
    req = "R4"; ch_low = '0; step(S + 2);
    ch_low = 6'b110011; ch_on = 6'b001111; ch_fault = 6'b000011; step(3 * S);
    chk("R4 masked hold", ratio_sel, 4'b1000);
    ch_fault = '0; ch_on = '1;

    // R8: PWM off time holds the ratio
    req = "R8"; ch_on = '0; ch_low = '1; step(10 * S);
    chk("R8 off-time hold", ratio_sel, 4'b1000);
    ch_on = '1; ch_low = '0;

    // R6: priority of request over unity_ok, then fall back to 1x
    req = "R6"; unity_ok = 1'b1; ch_low = 6'b100000; step(1);
    chk("R6 request wins", ratio_sel, 4'b0001);
    step(S); chk("R6 climbs despite unity_ok", ratio_sel, 4'b0010);
    ch_low = '0; step(S); chk("R6 back to 1x", ratio_sel, 4'b0001);
    step(3 * S); chk("R6 stays 1x", ratio_sel, 4'b0001);
    unity_ok = 1'b0;

    // R5: short pulse inside a window is ignored
    req = "R5"; ch_low = 6'b000001; step(1); ch_low = '0;
    step(2); ch_low = 6'b000001; step(2); ch_low = '0; step(S);
    chk("R5 single step only", ratio_sel, 4'b0010);

    // R1: disable mid-run
    req = "R1"; enable = 1'b0; step(1);
    chk("R1 disable idle", ratio_sel, 4'b0000);
    chk("R1 good low", {3'b0, reg_good}, 4'b0000);

    // R10 and general: random stimulus compared against the model
    req = "R10"; enable = 1'b1;
    for (int k = 0; k < 3000; k++) begin
      ch_low   = NCH'($urandom);
      ch_on    = NCH'($urandom);
      ch_fault = NCH'($urandom) & NCH'($urandom);
      unity_ok = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 199) == 0) enable = 1'b0;
      else enable = 1'b1;
      step(1);
    end
    enable = 1'b0; step(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule